// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block is a general-purpose I/O controller that a processor reaches over a 16-bit register bus. It serves a bank of 32 bidirectional pins, each able to raise an interrupt, and a bank of 18 pins that can only be driven. Each bidirectional pin has a direction bit that controls its output enable. An input pin passes through a two-flop synchroniser. A per-pin detector then looks for the event that software has configured.

Each pin picks its trigger on its own: level or edge, high or low polarity, and a status bit that either latches until cleared or follows the live condition. Status bits are cleared by writing 1 to them. The enabled status bits are ORed into one registered interrupt line. Every 32-bit register is split into two halfwords, and the interrupt service routine clears what it has read by writing the same value back to the status register.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all configuration, data and status registers read 0, `pin_oe` and `oo_pins` are 0 and `irq` is 0. The bidirectional data register then returns the synchronised pin levels, because every pin is an input.
- R2: `bus_addr[3:1]` selects the register: 0 direction, 1 bidirectional data, 2 output-only data, 3 interrupt enable, 4 status, 5 trigger type, 6 polarity, 7 latch mode. `bus_addr[0]`=0 reaches bits 15:0 and `bus_addr[0]`=1 reaches bits 31:16. A write happens when `bus_sel` and `bus_we` are both high at a clock edge. Read data is combinational.
- R3: A direction bit of 1 makes the pin an output and drives `pin_oe`. The data register drives `pin_out`. A read of the data register returns the stored value for output pins and the synchronised pin level for input pins.
- R4: Bit n of the output-only data register drives `oo_pins[n]`. Register bits above 17 read as 0.
- R5: With a type bit of 0 (level) and a latch bit of 0, the status bit follows the live condition: pin high when the polarity bit is 1, pin low when it is 0. It sets on the third clock edge after the pin changes and clears the same way.
- R6: With a type bit of 1 (edge), a polarity bit of 1 detects rising edges and 0 detects falling edges. Each edge produces a one-cycle event, so with a latch bit of 0 the status bit is high for exactly one cycle.
- R7: With a latch bit of 1, a detected event stays in status until a 1 is written to that status bit. Writing 0 leaves it unchanged.
- R8: When a clear and a new event meet at the same clock edge, the status bit stays 1.
- R9: The enable bits gate status into `irq` but do not hide status from reads. `irq` is registered and rises one clock after an enabled status bit sets.
- R10: A pin set as an output never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Halfword address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pin_in | input | 32 | Sampled level of the bidirectional pins |
| pin_out | output | 32 | Drive value of the bidirectional pins |
| pin_oe | output | 32 | Output enable of the bidirectional pins |
| oo_pins | output | 18 | Output-only bank |
| irq | output | 1 | Combined interrupt |

## Verification
A software clear of a latched status bit can land on the same clock edge as a new event on that pin. To provoke this, the bench raises a pin configured for rising-edge latching and times a write-1-to-clear so that the bus write is captured on the exact edge where the detector fires. The status bit must still read 1 afterwards, and a second clear with no event pending must bring it to 0. The same collision is also applied to a latched level pin that is held active, where the bit must stay set.

// File: rtl/gpio_unit_pkg.sv
package gpio_unit_pkg;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_DAT  = 3'd1,
        SEL_ODAT = 3'd2,
        SEL_EN   = 3'd3,
        SEL_STAT = 3'd4,
        SEL_TYPE = 3'd5,
        SEL_LVL  = 3'd6,
        SEL_HOLD = 3'd7
    } reg_sel_e;

    localparam int HALF_W = 16;

    // Replace one halfword of a 32-bit word.
    function automatic logic [31:0] half_merge(input logic [31:0] cur,
                                               input logic        upper,
                                               input logic [15:0] d);
        logic [31:0] r;
        r = cur;
        if (upper) r[31:16] = d;
        else       r[15:0]  = d;
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
        logic [W-1:0] old;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = raw;
        sync_d.stab = sync_q.meta;
        sync_d.old  = sync_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign cur  = sync_q.stab;
    assign prev = sync_q.old;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir,
    output logic [W-1:0] ev
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic lvl_hit;
        logic edge_hit;
        assign lvl_hit  = lvl[i] ? cur[i] : ~cur[i];
        assign edge_hit = lvl[i] ? (cur[i] & ~prev[i]) : (~cur[i] & prev[i]);
        // R10: output pins are not event sources
        assign ev[i]    = ~dir[i] & (typ[i] ? edge_hit : lvl_hit);
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_unit_pkg::*;
#(
    parameter int BI_W = 32,
    parameter int OO_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [3:0]      bus_addr,
    input  logic [15:0]     bus_wdata,
    output logic [15:0]     bus_rdata,
    input  logic [BI_W-1:0] pin_in,
    output logic [BI_W-1:0] pin_out,
    output logic [BI_W-1:0] pin_oe,
    output logic [OO_W-1:0] oo_pins,
    output logic            irq
);
    localparam int REG_W = 2 * HALF_W;

    typedef struct packed {
        logic [BI_W-1:0] dir;
        logic [BI_W-1:0] dat;
        logic [OO_W-1:0] odat;
        logic [BI_W-1:0] en;
        logic [BI_W-1:0] st;
        logic [BI_W-1:0] typ;
        logic [BI_W-1:0] lvl;
        logic [BI_W-1:0] hold;
        logic            irq;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [BI_W-1:0] cur, prev, ev, clr, keep_mask;
    logic [REG_W-1:0] rd_word;
    reg_sel_e        sel;
    logic            upper, wr_go;

    assign sel   = reg_sel_e'(bus_addr[3:1]);
    assign upper = bus_addr[0];
    assign wr_go = bus_sel & bus_we;

    gpio_in_sync #(.W(BI_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .cur   (cur),
        .prev  (prev)
    );

    gpio_evt_det #(.W(BI_W)) u_det (
        .cur  (cur),
        .prev (prev),
        .typ  (regs_q.typ),
        .lvl  (regs_q.lvl),
        .dir  (regs_q.dir),
        .ev   (ev)
    );

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr_go) begin
            case (sel)
                SEL_DIR:  regs_d.dir  = BI_W'(half_merge(REG_W'(regs_q.dir), upper, bus_wdata));
                SEL_DAT:  regs_d.dat  = BI_W'(half_merge(REG_W'(regs_q.dat), upper, bus_wdata));
                SEL_ODAT: regs_d.odat = OO_W'(half_merge(REG_W'(regs_q.odat), upper, bus_wdata));
                SEL_EN:   regs_d.en   = BI_W'(half_merge(REG_W'(regs_q.en), upper, bus_wdata));
                SEL_STAT: clr         = BI_W'(half_merge('0, upper, bus_wdata));
                SEL_TYPE: regs_d.typ  = BI_W'(half_merge(REG_W'(regs_q.typ), upper, bus_wdata));
                SEL_LVL:  regs_d.lvl  = BI_W'(half_merge(REG_W'(regs_q.lvl), upper, bus_wdata));
                SEL_HOLD: regs_d.hold = BI_W'(half_merge(REG_W'(regs_q.hold), upper, bus_wdata));
                default: ;
            endcase
        end
        // latched bits: clear then set (set wins); through bits: live event
        regs_d.st  = (regs_q.hold & ((regs_q.st & ~clr) | ev)) | (~regs_q.hold & ev);
        regs_d.irq = |(regs_q.st & regs_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_DIR:  rd_word = REG_W'(regs_q.dir);
            SEL_DAT:  rd_word = REG_W'((regs_q.dir & regs_q.dat) | (~regs_q.dir & cur));
            SEL_ODAT: rd_word = REG_W'(regs_q.odat);
            SEL_EN:   rd_word = REG_W'(regs_q.en);
            SEL_STAT: rd_word = REG_W'(regs_q.st);
            SEL_TYPE: rd_word = REG_W'(regs_q.typ);
            SEL_LVL:  rd_word = REG_W'(regs_q.lvl);
            SEL_HOLD: rd_word = REG_W'(regs_q.hold);
            default: ;
        endcase
        bus_rdata = upper ? rd_word[31:16] : rd_word[15:0];
    end

    assign pin_out = regs_q.dat;
    assign pin_oe  = regs_q.dir;
    assign oo_pins = regs_q.odat;
    assign irq     = regs_q.irq;

    assign keep_mask = regs_q.st & regs_q.hold & ~clr;

    a_r9_irq_follows_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(regs_q.st & regs_q.en)) |=> irq);
    a_r9_irq_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(regs_q.st & regs_q.en)) |=> !irq);
    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.st & $past(keep_mask)) == $past(keep_mask)));
    a_r10_out_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & regs_q.dir) == '0));
    a_r5_through_live: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.st & ~$past(regs_q.hold)) == ($past(ev) & ~$past(regs_q.hold))));
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
    localparam int CLK_P = 10;
    localparam logic [2:0] R_DIR = 3'd0, R_DAT = 3'd1, R_ODAT = 3'd2, R_EN = 3'd3,
                           R_ST = 3'd4, R_TYP = 3'd5, R_LVL = 3'd6, R_HOLD = 3'd7;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '1;
    logic [31:0] pin_out, pin_oe;
    logic [17:0] oo_pins;
    logic        irq;

    int n_vec = 0, n_bad = 0;

    gpio_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .oo_pins(oo_pins), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic wr32(logic [2:0] r, logic [31:0] d);
        wr({r, 1'b0}, d[15:0]);
        wr({r, 1'b1}, d[31:16]);
    endtask

    task automatic rd32(logic [2:0] r, output logic [31:0] d);
        bus_addr = {r, 1'b0}; #1 d[15:0]  = bus_rdata;
        bus_addr = {r, 1'b1}; #1 d[31:16] = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, bm;
        logic ty, lv, ho;
        int pins [4];
        pins = '{0, 5, 17, 31};

        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'd0, irq}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            rd32(3'(r), v);
            chk($sformatf("R1 reset reg %0d", r), v, (r == 1) ? 32'hFFFF_FFFF : 32'd0);
        end
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 oo_pins", {14'd0, oo_pins}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 halfword placement
        wr({R_TYP, 1'b0}, 16'h1234);
        wr({R_TYP, 1'b1}, 16'hABCD);
        rd32(R_TYP, v);
        chk("R2 halfwords", v, 32'hABCD_1234);
        wr({R_TYP, 1'b1}, 16'h0000);
        rd32(R_TYP, v);
        chk("R2 upper only", v, 32'h0000_1234);
        wr32(R_TYP, 0);

        // R3 direction and data
        wr32(R_DIR, 32'h0000_00FF);
        wr32(R_DAT, 32'h0000_00A5);
        chk("R3 pin_oe", pin_oe, 32'h0000_00FF);
        chk("R3 pin_out", pin_out, 32'h0000_00A5);
        rd32(R_DAT, v);
        chk("R3 data read mix", v, 32'hFFFF_FFA5);
        pin_in[9] = 0;
        repeat (3) @(negedge clk);
        rd32(R_DAT, v);
        chk("R3 input pin level", v, 32'hFFFF_FDA5);
        pin_in[9] = 1;
        repeat (3) @(negedge clk);

        // R10 output pin ignores its level
        pin_in[0] = 0;
        repeat (4) @(negedge clk);
        wr32(R_ST, 32'hFFFF_FFFF);
        rd32(R_ST, v);
        chk("R10 output pin no status", v, 0);
        wr32(R_DIR, 0);
        @(negedge clk);
        rd32(R_ST, v);
        chk("R10 input pin status", v, 32'h1);
        pin_in[0] = 1;
        repeat (4) @(negedge clk);
        wr32(R_DAT, 0);

        // R4 output-only bank
        wr({R_ODAT, 1'b0}, 16'hBEEF);
        wr({R_ODAT, 1'b1}, 16'hFFFF);
        chk("R4 oo_pins", {14'd0, oo_pins}, 32'h0003_BEEF);
        rd32(R_ODAT, v);
        chk("R4 read", v, 32'h0003_BEEF);

        // sweep: pins x (type, polarity, latch) : R5 R6 R7 R9
        for (int pi = 0; pi < 4; pi++) begin
            for (int m = 0; m < 8; m++) begin
                ty = m[2]; lv = m[1]; ho = m[0];
                bm = 32'd1 << pins[pi];
                wr32(R_TYP, ty ? bm : 0);
                wr32(R_LVL, lv ? bm : 0);
                wr32(R_HOLD, ho ? bm : 0);
                wr32(R_EN, bm);
                pin_in[pins[pi]] = ~lv;
                repeat (4) @(negedge clk);
                wr32(R_ST, 32'hFFFF_FFFF);
                rd32(R_ST, v);
                chk($sformatf("R7 idle p%0d m%0d", pins[pi], m), v, 0);
                @(negedge clk);
                chk($sformatf("R9 idle irq p%0d m%0d", pins[pi], m), {31'd0, irq}, 0);
                pin_in[pins[pi]] = lv;
                repeat (3) @(negedge clk);
                rd32(R_ST, v);
                chk($sformatf("R5/R6 set p%0d m%0d", pins[pi], m), v, bm);
                chk($sformatf("R9 irq lag p%0d m%0d", pins[pi], m), {31'd0, irq}, 0);
                @(negedge clk);
                rd32(R_ST, v);
                chk($sformatf("R6 one cycle p%0d m%0d", pins[pi], m), v, (ty && !ho) ? 0 : bm);
                chk($sformatf("R9 irq up p%0d m%0d", pins[pi], m), {31'd0, irq}, 1);
                pin_in[pins[pi]] = ~lv;
                repeat (3) @(negedge clk);
                rd32(R_ST, v);
                chk($sformatf("R5/R7 release p%0d m%0d", pins[pi], m), v, ho ? bm : 0);
                if (ho) begin
                    wr32(R_EN, 0);
                    @(negedge clk);
                    chk($sformatf("R9 gated irq p%0d m%0d", pins[pi], m), {31'd0, irq}, 0);
                    rd32(R_ST, v);
                    chk($sformatf("R9 status visible p%0d m%0d", pins[pi], m), v, bm);
                end
                wr32(R_ST, 0);
                rd32(R_ST, v);
                chk($sformatf("R7 write0 keeps p%0d m%0d", pins[pi], m), v, ho ? bm : 0);
                wr32(R_ST, bm);
                rd32(R_ST, v);
                chk($sformatf("R7 write1 clears p%0d m%0d", pins[pi], m), v, 0);
                pin_in[pins[pi]] = 1;
            end
        end
        wr32(R_EN, 0);

        // R8 clear meets rising edge on pin 3
        wr32(R_TYP, 32'h8); wr32(R_LVL, 32'h8); wr32(R_HOLD, 32'h8);
        pin_in[3] = 0;
        repeat (4) @(negedge clk);
        wr32(R_ST, 32'hFFFF_FFFF);
        rd32(R_ST, v);
        chk("R8 pre", v, 0);
        pin_in[3] = 1;
        @(negedge clk);
        wr({R_ST, 1'b0}, 16'h0008);
        rd32(R_ST, v);
        chk("R8 edge set wins", v, 32'h8);
        wr({R_ST, 1'b0}, 16'h0008);
        rd32(R_ST, v);
        chk("R8 later clear", v, 0);

        // R8 clear while latched level still active
        wr32(R_TYP, 0);
        repeat (3) @(negedge clk);
        wr({R_ST, 1'b0}, 16'h0008);
        rd32(R_ST, v);
        chk("R8 level held", v, 32'h8);
        pin_in[3] = 0;
        repeat (3) @(negedge clk);
        wr({R_ST, 1'b0}, 16'h0008);
        rd32(R_ST, v);
        chk("R8 level cleared", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule